// File: doc/BRIEF.md
# Test Access Port with Flash-Access Data Registers

This block is a four-wire test access port controller. It is clocked by the test clock, steered by the mode-select line, takes serial data in and drives serial data out. A 16-bit instruction register chooses which data register sits between serial in and serial out. The choices are a one-bit pass-through register, a 32-bit identification register, a short boundary chain, and four data registers for flash access: control, timing scale, address and data. The flash registers are for a flash controller outside this block. Each one takes a parallel value in the capture step and presents the shifted value on a parallel output in the update step. A one-cycle strobe marks each update.

There is no asynchronous test reset pin. The controller reaches its reset state when the mode-select line is held high for five test-clock cycles, and this works from any state. The boundary chain reads the pin sense lines in its capture step and loads a preset drive value in its update step. It raises a test-mode output while the pin-driving instruction is active. All interfaces are plain level or strobe signals. None of the block's edges needs back-pressure, so no valid/ready handshake is used.

Top module: `jtag_flash_tap`

## Requirements
- R1: Holding `tms` high for five rising edges of `tck` reaches the reset state from any state. While in that state, the next rising edge loads instruction 0x0004 (identify), clears every parallel update output and drops `pin_test_mode`.
- R2: The instruction register is 16 bits wide and shifts least significant bit first. In Capture-IR it loads 0x0001, and that value leaves on `tdo` during the following Shift-IR. The new instruction takes effect in Update-IR.
- R3: Instruction 0xFFFF, and every code not listed in R4, R5, R7 and R8, selects a one-bit pass-through register. That register captures 0, so the serial output is the serial input delayed by one shift, led by a 0.
- R4: Instruction 0x0004 selects a 32-bit identification register. It captures the parameter `ID_VALUE` and shifts it out least significant bit first.
- R5: Instructions 0x0082, 0x0083, 0x0084 and 0x0085 select the flash control (8 bits), scale (8 bits), address (16 bits) and data (8 bits) registers. In Capture-DR the selected register loads its `*_cap` input. In Shift-DR it shifts least significant bit first from `tdi`.
- R6: In Update-DR the selected register copies its shift stage to its `*_q` output. Its `*_stb` is then high for exactly the one `tck` cycle that follows. The other update outputs keep their values, and their strobes stay low. An instruction scan fires no strobe.
- R7: Instruction 0x0002 selects the boundary chain with `pin_test_mode` low. Capture-DR loads `pin_sense` (bit 0 shifts out first), and Update-DR loads `pin_drive`.
- R8: Instruction 0x0000 selects the same boundary chain with `pin_test_mode` high for as long as it is the active instruction.
- R9: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR. In every other state `tdo_oe` and `tdo` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while shifting |
| pin_sense | input | BSR_LEN | Pin values captured by the boundary chain |
| pin_drive | output | BSR_LEN | Boundary chain update value |
| pin_test_mode | output | 1 | High while the pin-driving instruction is active |
| bsr_stb | output | 1 | Boundary chain update strobe |
| fctl_cap | input | CTL_W | Parallel capture value, flash control |
| fctl_q | output | CTL_W | Parallel update value, flash control |
| fctl_stb | output | 1 | Update strobe, flash control |
| fscl_cap | input | SCL_W | Parallel capture value, flash scale |
| fscl_q | output | SCL_W | Parallel update value, flash scale |
| fscl_stb | output | 1 | Update strobe, flash scale |
| fadr_cap | input | ADR_W | Parallel capture value, flash address |
| fadr_q | output | ADR_W | Parallel update value, flash address |
| fadr_stb | output | 1 | Update strobe, flash address |
| fdat_cap | input | DAT_W | Parallel capture value, flash data |
| fdat_q | output | DAT_W | Parallel update value, flash data |
| fdat_stb | output | 1 | Update strobe, flash data |

## Verification
The bench resets the controller from many states, each reached by a different mode-select walk, and then reads the identification code. A state graph that does not reach reset within five high cycles from some state would read back a pass-through bit instead of the identification code. It sweeps the codes next to the flash codes and other sparse values. A decoder that compares too few bits would alias one of them onto a flash or boundary register instead of the one-bit pass-through. Each flash register is written in turn, with every update output and strobe checked. A strobe that lasts too long or fires on the wrong register shows as a second high cycle or a disturbed neighbour. Off-by-one shifts, a wrong capture pattern and a wrong `tdo` edge show up as shifted or misaligned serial data.

// File: rtl/jtf_pkg.sv
package jtf_pkg;

  localparam int IR_W = 16;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    SEL_PASS, SEL_BSR, SEL_ID, SEL_FCTL, SEL_FSCL, SEL_FADR, SEL_FDAT
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_PINDRIVE = 16'h0000;
  localparam logic [IR_W-1:0] OP_PINSAMP  = 16'h0002;
  localparam logic [IR_W-1:0] OP_IDENT    = 16'h0004;
  localparam logic [IR_W-1:0] OP_FCTL     = 16'h0082;
  localparam logic [IR_W-1:0] OP_FSCL     = 16'h0083;
  localparam logic [IR_W-1:0] OP_FADR     = 16'h0084;
  localparam logic [IR_W-1:0] OP_FDAT     = 16'h0085;
  localparam logic [IR_W-1:0] IR_CAP_PAT  = 16'h0001;

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    dr_sel_e s;
    case (op)
      OP_PINDRIVE, OP_PINSAMP: s = SEL_BSR;
      OP_IDENT:                s = SEL_ID;
      OP_FCTL:                 s = SEL_FCTL;
      OP_FSCL:                 s = SEL_FSCL;
      OP_FADR:                 s = SEL_FADR;
      OP_FDAT:                 s = SEL_FDAT;
      default:                 s = SEL_PASS;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/jtf_fsm.sv
module jtf_fsm
  import jtf_pkg::*;
(
  input  logic       tck,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
    endcase
  end

  always_ff @(posedge tck) state <= nxt;

endmodule

// File: rtl/jtf_ir.sv
module jtf_ir
  import jtf_pkg::*;
(
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sr,
  output dr_sel_e         sel,
  output logic            pin_mode
);

  always_ff @(posedge tck) begin
    case (st)
      S_TLR:    ir_q  <= OP_IDENT;
      S_CAP_IR: ir_sr <= IR_CAP_PAT;
      S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      S_UPD_IR: ir_q  <= ir_sr;
      default: ;
    endcase
  end

  assign sel      = decode_op(ir_q);
  assign pin_mode = (ir_q == OP_PINDRIVE);

endmodule

// File: rtl/jtf_dreg.sv
module jtf_dreg
  import jtf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         tdi,
  input  tap_state_e   st,
  input  logic         en,
  input  logic [W-1:0] cap,
  output logic         so,
  output logic [W-1:0] q,
  output logic         stb
);

  logic [W-1:0] sr;

  always_ff @(posedge tck) begin
    stb <= 1'b0;
    if (st == S_TLR) begin
      q <= '0;
    end else if (en) begin
      case (st)
        S_CAP_DR: sr <= cap;
        S_SH_DR:  sr <= {tdi, sr[W-1:1]};
        S_UPD_DR: begin
          q   <= sr;
          stb <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign so = sr[0];

endmodule

// File: rtl/jtag_flash_tap.sv
module jtag_flash_tap
  import jtf_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter int          CTL_W    = 8,
  parameter int          SCL_W    = 8,
  parameter int          ADR_W    = 16,
  parameter int          DAT_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A06_0243
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_sense,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic               pin_test_mode,
  output logic               bsr_stb,
  input  logic [CTL_W-1:0]   fctl_cap,
  output logic [CTL_W-1:0]   fctl_q,
  output logic               fctl_stb,
  input  logic [SCL_W-1:0]   fscl_cap,
  output logic [SCL_W-1:0]   fscl_q,
  output logic               fscl_stb,
  input  logic [ADR_W-1:0]   fadr_cap,
  output logic [ADR_W-1:0]   fadr_q,
  output logic               fadr_stb,
  input  logic [DAT_W-1:0]   fdat_cap,
  output logic [DAT_W-1:0]   fdat_q,
  output logic               fdat_stb
);

  localparam int ID_W = 32;

  tap_state_e      fsm_state;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sr;
  dr_sel_e         sel;
  logic            so_bsr, so_ctl, so_scl, so_adr, so_dat;
  logic            pass_bit;
  logic [ID_W-1:0] id_sr;
  logic            dr_bit, out_bit, shifting;

  jtf_fsm u_fsm (.tck(tck), .tms(tms), .state(fsm_state));

  jtf_ir u_ir (
    .tck(tck), .tdi(tdi), .st(fsm_state),
    .ir_q(ir_q), .ir_sr(ir_sr), .sel(sel), .pin_mode(pin_test_mode)
  );

  jtf_dreg #(.W(BSR_LEN)) u_bsr (
    .tck(tck), .tdi(tdi), .st(fsm_state), .en(sel == SEL_BSR),
    .cap(pin_sense), .so(so_bsr), .q(pin_drive), .stb(bsr_stb)
  );
  jtf_dreg #(.W(CTL_W)) u_fctl (
    .tck(tck), .tdi(tdi), .st(fsm_state), .en(sel == SEL_FCTL),
    .cap(fctl_cap), .so(so_ctl), .q(fctl_q), .stb(fctl_stb)
  );
  jtf_dreg #(.W(SCL_W)) u_fscl (
    .tck(tck), .tdi(tdi), .st(fsm_state), .en(sel == SEL_FSCL),
    .cap(fscl_cap), .so(so_scl), .q(fscl_q), .stb(fscl_stb)
  );
  jtf_dreg #(.W(ADR_W)) u_fadr (
    .tck(tck), .tdi(tdi), .st(fsm_state), .en(sel == SEL_FADR),
    .cap(fadr_cap), .so(so_adr), .q(fadr_q), .stb(fadr_stb)
  );
  jtf_dreg #(.W(DAT_W)) u_fdat (
    .tck(tck), .tdi(tdi), .st(fsm_state), .en(sel == SEL_FDAT),
    .cap(fdat_cap), .so(so_dat), .q(fdat_q), .stb(fdat_stb)
  );

  // pass-through and identification stages have no update side
  always_ff @(posedge tck) begin
    if (sel == SEL_PASS) begin
      if (fsm_state == S_CAP_DR)     pass_bit <= 1'b0;
      else if (fsm_state == S_SH_DR) pass_bit <= tdi;
    end
    if (sel == SEL_ID) begin
      if (fsm_state == S_CAP_DR)     id_sr <= ID_VALUE;
      else if (fsm_state == S_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_comb begin
    case (sel)
      SEL_BSR:  dr_bit = so_bsr;
      SEL_ID:   dr_bit = id_sr[0];
      SEL_FCTL: dr_bit = so_ctl;
      SEL_FSCL: dr_bit = so_scl;
      SEL_FADR: dr_bit = so_adr;
      SEL_FDAT: dr_bit = so_dat;
      default:  dr_bit = pass_bit;
    endcase
  end

  assign shifting = (fsm_state == S_SH_DR) || (fsm_state == S_SH_IR);
  assign out_bit  = (fsm_state == S_SH_IR) ? ir_sr[0] : dr_bit;

  always_ff @(negedge tck) begin
    tdo_oe <= shifting;
    tdo    <= shifting & out_bit;
  end

endmodule

// File: rtl/jtf_checks.sv
module jtf_checks
  import jtf_pkg::*;
(
  input logic            tck,
  input logic            tms,
  input tap_state_e      st,
  input logic [IR_W-1:0] ir_q,
  input logic [1:0]      ir_lo,
  input logic [4:0]      stbs,
  input logic            tdo,
  input logic            tdo_oe,
  input logic            test_mode
);

  logic       synced = 1'b0;
  logic [2:0] ones   = 3'd0;

  always_ff @(posedge tck) begin
    if (st == S_TLR) synced <= 1'b1;
    if (!tms)              ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  assert_five_ones_R1: assert property (@(posedge tck) disable iff (!synced)
    (ones == 3'd5) |-> (st == S_TLR));

  assert_reset_ident_R1: assert property (@(posedge tck) disable iff (!synced)
    (st == S_TLR) |=> (ir_q == OP_IDENT));

  assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!synced)
    (st == S_CAP_IR) |=> (ir_lo == 2'b01));

  assert_one_strobe_R6: assert property (@(posedge tck) disable iff (!synced)
    $onehot0(stbs));

  assert_strobe_pulse_R6: assert property (@(posedge tck) disable iff (!synced)
    (|stbs) |=> !(|stbs));

  assert_mode_on_update_R8: assert property (@(posedge tck) disable iff (!synced)
    $rose(test_mode) |-> ($past(st) == S_UPD_IR));

  assert_oe_shift_only_R9: assert property (@(posedge tck) disable iff (!synced)
    tdo_oe |-> (st == S_SH_DR || st == S_SH_IR));

  assert_idle_low_R9: assert property (@(posedge tck) disable iff (!synced)
    !tdo_oe |-> !tdo);

endmodule

bind jtag_flash_tap jtf_checks u_checks (
  .tck(tck), .tms(tms), .st(fsm_state), .ir_q(ir_q), .ir_lo(ir_sr[1:0]),
  .stbs({fdat_stb, fadr_stb, fscl_stb, fctl_stb, bsr_stb}),
  .tdo(tdo), .tdo_oe(tdo_oe), .test_mode(pin_test_mode)
);

// File: tb/jtag_flash_tap_test.sv
`timescale 1ns/1ps
module jtag_flash_tap_test;
  localparam logic [31:0] IDV = 32'h1A06_0243;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, pin_test_mode, bsr_stb;
  logic [7:0]  pin_sense = 8'h00, pin_drive;
  logic [7:0]  fctl_cap = 8'h5A, fctl_q;
  logic [7:0]  fscl_cap = 8'h3C, fscl_q;
  logic [15:0] fadr_cap = 16'hBEEF, fadr_q;
  logic [7:0]  fdat_cap = 8'h96, fdat_q;
  logic fctl_stb, fscl_stb, fadr_stb, fdat_stb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  jtag_flash_tap #(.ID_VALUE(IDV)) uut (
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_sense(pin_sense), .pin_drive(pin_drive), .pin_test_mode(pin_test_mode),
    .bsr_stb(bsr_stb),
    .fctl_cap(fctl_cap), .fctl_q(fctl_q), .fctl_stb(fctl_stb),
    .fscl_cap(fscl_cap), .fscl_q(fscl_q), .fscl_stb(fscl_stb),
    .fadr_cap(fadr_cap), .fadr_q(fadr_q), .fadr_stb(fadr_stb),
    .fdat_cap(fdat_cap), .fdat_q(fdat_q), .fdat_stb(fdat_stb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one TCK cycle: drive after the falling edge, sample tdo there, return after rising edge
  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo; oe = tdo_oe;
    @(posedge tck); #1;
  endtask

  task automatic go_reset();
    logic o, oe;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
  endtask

  // from Run-Test/Idle, full scan, back to Run-Test/Idle; ends one edge after Update
  task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                      output logic [63:0] dout, output bit oe_ok);
    logic o, oe;
    dout = '0; oe_ok = 1'b1;
    tick(1'b1, 1'b0, o, oe); oe_ok &= !oe && !o;
    if (is_ir) begin tick(1'b1, 1'b0, o, oe); oe_ok &= !oe && !o; end
    tick(1'b0, 1'b0, o, oe); oe_ok &= !oe && !o;
    tick(1'b0, 1'b0, o, oe); oe_ok &= !oe && !o;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, oe);
      dout[i] = o; oe_ok &= oe;
    end
    tick(1'b1, 1'b0, o, oe); oe_ok &= !oe && !o;
    tick(1'b0, 1'b0, o, oe); oe_ok &= !oe && !o;
  endtask

  task automatic set_ir(input logic [15:0] op);
    logic [63:0] d; bit ok;
    scan(1'b1, 16, {48'd0, op}, d, ok);
  endtask

  function automatic logic [4:0] stbv();
    return {fdat_stb, fadr_stb, fscl_stb, fctl_stb, bsr_stb};
  endfunction

  initial begin
    logic [63:0] d, m, cexp, wv;
    logic [15:0] qexp [4];
    logic o, oe;
    bit ok;
    int w;

    go_reset();
    chk("R1 reset clears updates", {fctl_q, fscl_q, fadr_q, fdat_q, pin_drive}, 64'd0);
    chk("R1 reset test mode low", pin_test_mode, 0);
    chk("R9 idle tdo_oe/tdo", {tdo_oe, tdo}, 0);

    scan(1'b0, 32, 64'd0, d, ok);
    chk("R4 ident after reset", d[31:0], IDV);
    chk("R9 oe only while shifting", ok, 1);

    scan(1'b1, 16, 64'hFFFF, d, ok);
    chk("R2 capture pattern", d[15:0], 16'h0001);
    chk("R6 no strobe on instruction scan", stbv(), 0);
    chk("R9 oe during instruction scan", ok, 1);
    scan(1'b0, 9, 64'h16D, d, ok);
    chk("R3 pass-through 0xFFFF", d[8:0], {8'h6D, 1'b0});

    // sweep of unlisted codes: all must act as pass-through
    for (int k = 0; k < 24; k++) begin
      logic [15:0] op;
      if (k < 16) op = 16'h0080 + 16'(k);
      else op = (k == 16) ? 16'h0001 : (k == 17) ? 16'h0003 : (k == 18) ? 16'h0006 :
                (k == 19) ? 16'h0100 : (k == 20) ? 16'h8000 : (k == 21) ? 16'h7FFF :
                (k == 22) ? 16'h8082 : 16'h0184;
      if (op < 16'h0082 || op > 16'h0085) begin
        set_ir(op);
        scan(1'b0, 9, 64'h0B3, d, ok);
        chk($sformatf("R3 unlisted code %h", op), d[8:0], {8'hB3, 1'b0});
      end
    end

    // flash registers in turn
    for (int k = 0; k < 4; k++) qexp[k] = 16'h0;
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin w = 8;  cexp = 64'h5A;   wv = 64'hE1;   end
        1: begin w = 8;  cexp = 64'h3C;   wv = 64'h7B;   end
        2: begin w = 16; cexp = 64'hBEEF; wv = 64'h1234; end
        default: begin w = 8; cexp = 64'h96; wv = 64'h4D; end
      endcase
      m = (64'd1 << w) - 64'd1;
      set_ir(16'h0082 + 16'(k));
      scan(1'b0, w, wv, d, ok);
      qexp[k] = wv[15:0];
      chk($sformatf("R5 capture reg %0d", k), d & m, cexp);
      chk($sformatf("R6 strobe reg %0d", k), stbv(), 5'b00010 << k);
      chk($sformatf("R6 outputs after reg %0d", k),
          {fctl_q, fscl_q, fadr_q, fdat_q},
          {qexp[0][7:0], qexp[1][7:0], qexp[2], qexp[3][7:0]});
      tick(1'b0, 1'b0, o, oe);
      chk($sformatf("R6 strobe one cycle reg %0d", k), stbv(), 0);
    end

    // boundary chain
    pin_sense = 8'hA5;
    set_ir(16'h0002);
    chk("R7 sample mode low", pin_test_mode, 0);
    scan(1'b0, 8, 64'h3C, d, ok);
    chk("R7 pins captured", d[7:0], 8'hA5);
    chk("R7 preset loaded", pin_drive, 8'h3C);
    chk("R7 boundary strobe", stbv(), 5'b00001);
    pin_sense = 8'h4E;
    set_ir(16'h0000);
    chk("R8 pin test mode high", pin_test_mode, 1);
    scan(1'b0, 8, 64'hC7, d, ok);
    chk("R8 pins captured", d[7:0], 8'h4E);
    chk("R8 drive loaded", pin_drive, 8'hC7);
    set_ir(16'hFFFF);
    chk("R8 mode drops on other instruction", pin_test_mode, 0);

    // reset from many states reached by distinct mode-select walks
    for (int i = 0; i < 20; i++) begin
      logic [15:0] pat;
      set_ir(16'h0082);
      scan(1'b0, 8, 64'hA5, d, ok);
      set_ir((i % 2) ? 16'h0000 : 16'hFFFF);
      pat = 16'h9C5A ^ 16'(i * 16'h1337);
      for (int j = 0; j < (i % 16); j++) tick(pat[j], 1'b1, o, oe);
      go_reset();
      chk($sformatf("R1 cleared after walk %0d", i), {fctl_q, pin_test_mode}, 0);
      scan(1'b0, 32, 64'd0, d, ok);
      chk($sformatf("R1 ident after walk %0d", i), d[31:0], IDV);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule